// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block arbitrates among three CAN transmit message buffers. Each buffer has a stored 2-bit priority, an interrupt enable and a transmit request bit. Software writes these through a single register-style write port. When the attached frame transmitter reports that the bus is free, the scheduler picks the highest-priority pending buffer and issues a one-cycle start pulse together with the buffer index. It then waits for a single completion report from the transmitter: success, error or lost arbitration.

Each buffer keeps sticky flags for abort, lost arbitration and error, plus a completion interrupt flag that software clears. A failed attempt leaves the buffer pending, so it is retried at the next free bus. Software can withdraw one buffer by writing its request bit low, or it can raise a global abort that withdraws every pending buffer. A buffer that is already on the bus is withdrawn only if its attempt fails. The global abort clears itself once no request remains. Message data, bit timing and serialization belong to the transmitter and are not part of this block.

Top module: `can_txq_sched`

## Requirements
- R1: After a synchronous active-low reset, all request, abort, lost-arbitration, error and interrupt flags are 0, the global abort is 0, the block is not busy, and `tx_start` is 0.
- R2: When the block is not busy, `bus_idle` is 1, at least one request is pending and the global abort is clear, `tx_start` is 1 in that same cycle and `tx_idx` names the pending buffer with the highest priority (code 3 highest, code 0 lowest). The block is busy from the next cycle.
- R3: When pending buffers share the top priority, the buffer with the highest index wins.
- R4: A write with `cfg_req`=1 sets that buffer's request and clears its abort, lost-arbitration and error flags at the next edge.
- R5: A completion with `tx_res`=00 (success) clears the buffer's request bit. It sets the buffer's interrupt flag only if that buffer's interrupt enable is 1. An interrupt flag can rise only after such a completion.
- R6: A completion with `tx_res`=01 or 11 (error) sets the error flag, keeps the request set and raises no interrupt. The buffer is started again at the next free bus.
- R7: A completion with `tx_res`=10 (lost arbitration) sets the lost-arbitration flag, keeps the request set and raises no interrupt.
- R8: A write with `cfg_req`=0 to a pending buffer that is not on the bus clears its request and sets its abort flag at the next edge, without an interrupt.
- R9: An abort aimed at the buffer on the bus is held back. If the attempt then succeeds, it completes normally and the abort flag stays 0. If the attempt ends in error or lost arbitration, the request clears and the abort flag is set along with the failure flag.
- R10: `gab_set` raises the global abort. While it is set, no transmission starts and every pending buffer is aborted as in R8 and R9. It clears itself one cycle after no request remains.
- R11: Selection uses the priority values held in the cycle of the start, so a priority rewritten before that cycle is honoured.
- R12: Only one attempt is outstanding at a time: `tx_start` stays 0 while the block is busy, and `tx_done` is ignored while the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one buffer's control |
| cfg_sel | input | IDX_W | Buffer addressed by the write |
| cfg_req | input | 1 | 1 enqueues the buffer, 0 requests its abort |
| cfg_pri | input | PRI_W | Priority written to the buffer |
| cfg_ie | input | 1 | Completion interrupt enable written to the buffer |
| gab_set | input | 1 | Raises the global abort |
| irq_clr | input | NBUF | Per-buffer clear of the interrupt flag |
| bus_idle | input | 1 | Transmitter can begin a frame |
| tx_start | output | 1 | One-cycle start of an attempt |
| tx_idx | output | IDX_W | Buffer chosen, or buffer on the bus while busy |
| tx_done | input | 1 | Attempt finished (used only while busy) |
| tx_res | input | 2 | Outcome: 00 success, 01/11 error, 10 lost arbitration |
| req_o | output | NBUF | Request bits |
| abt_o | output | NBUF | Abort flags |
| lab_o | output | NBUF | Lost-arbitration flags |
| err_o | output | NBUF | Error flags |
| irq_o | output | NBUF | Completion interrupt flags |
| gab_o | output | 1 | Global abort in progress |
| busy_o | output | 1 | An attempt is outstanding |

## Verification
The bench builds the block with its defaults: three buffers and 2-bit priorities. This keeps the whole selection space small enough to sweep. Every non-empty request subset is crossed with all 64 priority assignments, and the expected winner comes from an arithmetic scan in the bench. Each sweep step is then cleared through the global abort, which also exercises its self-clearing. The configuration is small, so directed sequences can reach every outcome code against an in-flight buffer with and without a pending abort.

// File: rtl/can_txq_pkg.sv
// Shared definitions for the CAN transmit buffer scheduler.
// Assumes the transmitter reports exactly one outcome per started attempt.
package can_txq_pkg;
    localparam int unsigned RES_W = 2;

    // Outcome codes reported by the frame transmitter; 2'b11 counts as error.
    typedef enum logic [RES_W-1:0] {
        RES_OK   = 2'b00,
        RES_ERR  = 2'b01,
        RES_LOST = 2'b10,
        RES_ERR2 = 2'b11
    } txq_res_e;
endpackage

// File: rtl/txq_buf_ctl.sv
// Control and flag state for one transmit buffer.
// Assumes in_flight covers the start cycle and the whole attempt; fin is the
// completion of this buffer's attempt. An abort aimed at an in-flight buffer
// is held in abt_pend and resolved by the outcome.
module txq_buf_ctl
    import can_txq_pkg::*;
#(
    parameter int unsigned PRI_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_req,
    input  logic [PRI_W-1:0] wr_pri,
    input  logic             wr_ie,
    input  logic             gab,
    input  logic             in_flight,
    input  logic             fin,
    input  logic [RES_W-1:0] fin_res,
    input  logic             irq_clr,
    output logic             req,
    output logic [PRI_W-1:0] pri,
    output logic             ie,
    output logic             abt,
    output logic             lab,
    output logic             err,
    output logic             irq
);
    logic abt_pend;
    logic kill;
    logic retire;

    // Abort demand this cycle, from software or the global abort.
    assign kill   = (wr_en && !wr_req) || gab;
    // A failed attempt ends the request if any abort is outstanding.
    assign retire = abt_pend || kill;

    // Request, flag and deferred-abort state of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            pri      <= '0;
            ie       <= 1'b0;
            abt      <= 1'b0;
            lab      <= 1'b0;
            err      <= 1'b0;
            irq      <= 1'b0;
            abt_pend <= 1'b0;
        end else begin
            if (irq_clr) irq <= 1'b0;
            if (wr_en) begin
                pri <= wr_pri;
                ie  <= wr_ie;
            end
            if (in_flight) begin
                if (fin) begin
                    abt_pend <= 1'b0;
                    case (txq_res_e'(fin_res))
                        RES_OK: begin
                            req <= 1'b0;
                            if (ie) irq <= 1'b1;
                        end
                        RES_LOST: begin
                            lab <= 1'b1;
                            if (retire) begin
                                req <= 1'b0;
                                abt <= 1'b1;
                            end
                        end
                        default: begin
                            err <= 1'b1;
                            if (retire) begin
                                req <= 1'b0;
                                abt <= 1'b1;
                            end
                        end
                    endcase
                end else if (kill && req) begin
                    abt_pend <= 1'b1;
                end
            end else if (kill && req) begin
                req <= 1'b0;
                abt <= 1'b1;
            end
            if (wr_en && wr_req) begin
                req      <= 1'b1;
                abt      <= 1'b0;
                lab      <= 1'b0;
                err      <= 1'b0;
                abt_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txq_pick.sv
// Combinational selection of the pending buffer with the highest priority.
// Ties go to the highest index because later entries win on equality.
module txq_pick #(
    parameter int unsigned NBUF  = 3,
    parameter int unsigned PRI_W = 2,
    parameter int unsigned IDX_W = 2
) (
    input  logic [NBUF-1:0]       pend,
    input  logic [NBUF*PRI_W-1:0] pri_flat,
    output logic                  any,
    output logic [IDX_W-1:0]      win
);
    logic [PRI_W-1:0] best;

    // Linear scan keeping the best priority seen so far.
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (pend[i] && (!any || pri_flat[i*PRI_W +: PRI_W] >= best)) begin
                any  = 1'b1;
                win  = IDX_W'(i);
                best = pri_flat[i*PRI_W +: PRI_W];
            end
        end
    end
endmodule

// File: rtl/txq_seq.sv
// Attempt sequencer: idle until a start, busy until the transmitter reports.
// Assumes start is only raised while idle.
module txq_seq #(
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] pick,
    input  logic             done,
    output logic             busy,
    output logic [IDX_W-1:0] cur
);
    typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_st_e;
    seq_st_e st;

    assign busy = (st == ST_BUSY);

    // State and captured buffer index of the outstanding attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cur <= '0;
        end else if (st == ST_IDLE) begin
            if (start) begin
                st  <= ST_BUSY;
                cur <= pick;
            end
        end else if (done) begin
            st <= ST_IDLE;
        end
    end
endmodule

// File: rtl/can_txq_sched.sv
// CAN transmit buffer scheduler top: per-buffer control, selection,
// attempt sequencing and the self-clearing global abort.
// Assumes cfg_sel addresses an existing buffer.
module can_txq_sched
    import can_txq_pkg::*;
#(
    parameter int unsigned NBUF  = 3,
    parameter int unsigned PRI_W = 2,
    localparam int unsigned IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic             cfg_req,
    input  logic [PRI_W-1:0] cfg_pri,
    input  logic             cfg_ie,
    input  logic             gab_set,
    input  logic [NBUF-1:0]  irq_clr,
    input  logic             bus_idle,
    output logic             tx_start,
    output logic [IDX_W-1:0] tx_idx,
    input  logic             tx_done,
    input  logic [RES_W-1:0] tx_res,
    output logic [NBUF-1:0]  req_o,
    output logic [NBUF-1:0]  abt_o,
    output logic [NBUF-1:0]  lab_o,
    output logic [NBUF-1:0]  err_o,
    output logic [NBUF-1:0]  irq_o,
    output logic             gab_o,
    output logic             busy_o
);
    logic [NBUF*PRI_W-1:0] pri_flat;
    logic [NBUF-1:0]       ie_all;
    logic                  any_pend;
    logic [IDX_W-1:0]      pick;
    logic [IDX_W-1:0]      cur;
    logic                  gab_q;

    assign gab_o    = gab_q;
    assign tx_start = !busy_o && bus_idle && any_pend && !gab_q;
    assign tx_idx   = busy_o ? cur : pick;

    txq_pick #(.NBUF(NBUF), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_pick (
        .pend     (req_o),
        .pri_flat (pri_flat),
        .any      (any_pend),
        .win      (pick)
    );

    txq_seq #(.IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .pick  (pick),
        .done  (tx_done),
        .busy  (busy_o),
        .cur   (cur)
    );

    for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
        logic sel_hit;
        logic on_bus;
        assign sel_hit = cfg_we && (cfg_sel == IDX_W'(gi));
        assign on_bus  = (busy_o && cur == IDX_W'(gi)) ||
                         (tx_start && pick == IDX_W'(gi));

        txq_buf_ctl #(.PRI_W(PRI_W)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_hit),
            .wr_req    (cfg_req),
            .wr_pri    (cfg_pri),
            .wr_ie     (cfg_ie),
            .gab       (gab_q),
            .in_flight (on_bus),
            .fin       (busy_o && tx_done),
            .fin_res   (tx_res),
            .irq_clr   (irq_clr[gi]),
            .req       (req_o[gi]),
            .pri       (pri_flat[gi*PRI_W +: PRI_W]),
            .ie        (ie_all[gi]),
            .abt       (abt_o[gi]),
            .lab       (lab_o[gi]),
            .err       (err_o[gi]),
            .irq       (irq_o[gi])
        );
    end

    // Global abort: set on request, dropped once no request remains.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gab_q <= 1'b0;
        else if (gab_set)            gab_q <= 1'b1;
        else if (gab_q && req_o == '0) gab_q <= 1'b0;
    end
endmodule

// File: rtl/can_txq_chk.sv
// Protocol checker for can_txq_sched, bound to every instance of the top.
module can_txq_chk #(
    parameter int unsigned NBUF  = 3,
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [IDX_W-1:0] cfg_sel,
    input logic             cfg_req,
    input logic             tx_start,
    input logic [IDX_W-1:0] tx_idx,
    input logic             tx_done,
    input logic [1:0]       tx_res,
    input logic [NBUF-1:0]  req_o,
    input logic [NBUF-1:0]  abt_o,
    input logic [NBUF-1:0]  lab_o,
    input logic [NBUF-1:0]  err_o,
    input logic [NBUF-1:0]  irq_o,
    input logic             gab_o,
    input logic             busy_o
);
    logic [NBUF-1:0] irq_q;
    logic            ok_q;

    // Previous interrupt flags and whether a success was reported last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            irq_q <= irq_o;
            ok_q  <= busy_o && tx_done && (tx_res == 2'b00);
        end
    end

    p_pick_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> req_o[tx_idx]);

    p_set_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_req && cfg_sel < IDX_W'(NBUF)) |=>
        (!abt_o[$past(cfg_sel)] && !lab_o[$past(cfg_sel)] &&
         !err_o[$past(cfg_sel)] && req_o[$past(cfg_sel)]));

    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_o & ~irq_q)) |-> ok_q);

    p_idle_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_req && cfg_sel < IDX_W'(NBUF) && req_o[cfg_sel] &&
         !tx_start && !(busy_o && tx_idx == cfg_sel)) |=>
        (!req_o[$past(cfg_sel)] && abt_o[$past(cfg_sel)]));

    p_gab_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gab_o |-> !tx_start);

    p_single_attempt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (busy_o && !tx_start));
endmodule

bind can_txq_sched can_txq_chk #(.NBUF(NBUF), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_req  (cfg_req),
    .tx_start (tx_start),
    .tx_idx   (tx_idx),
    .tx_done  (tx_done),
    .tx_res   (tx_res),
    .req_o    (req_o),
    .abt_o    (abt_o),
    .lab_o    (lab_o),
    .err_o    (err_o),
    .irq_o    (irq_o),
    .gab_o    (gab_o),
    .busy_o   (busy_o)
);

// File: tb/sim_can_txq_sched.sv
// Self-checking bench: directed outcome sequences plus a full sweep of
// request subsets against priority assignments.
module sim_can_txq_sched;
    localparam int NBUF  = 3;
    localparam int PRI_W = 2;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_sel = '0;
    logic             cfg_req = 1'b0;
    logic [PRI_W-1:0] cfg_pri = '0;
    logic             cfg_ie = 1'b0;
    logic             gab_set = 1'b0;
    logic [NBUF-1:0]  irq_clr = '0;
    logic             bus_idle = 1'b0;
    logic             tx_start;
    logic [IDX_W-1:0] tx_idx;
    logic             tx_done = 1'b0;
    logic [1:0]       tx_res = 2'b00;
    logic [NBUF-1:0]  req_o, abt_o, lab_o, err_o, irq_o;
    logic             gab_o, busy_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    can_txq_sched #(.NBUF(NBUF), .PRI_W(PRI_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_req(cfg_req), .cfg_pri(cfg_pri), .cfg_ie(cfg_ie),
        .gab_set(gab_set), .irq_clr(irq_clr), .bus_idle(bus_idle),
        .tx_start(tx_start), .tx_idx(tx_idx), .tx_done(tx_done),
        .tx_res(tx_res), .req_o(req_o), .abt_o(abt_o), .lab_o(lab_o),
        .err_o(err_o), .irq_o(irq_o), .gab_o(gab_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input bit rq, input int pr, input bit ie);
        cfg_we = 1'b1; cfg_sel = IDX_W'(sel); cfg_req = rq;
        cfg_pri = PRI_W'(pr); cfg_ie = ie;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Offer a free bus for one cycle and check the start and chosen index.
    task automatic go(input string tag, input bit exp_start, input int exp_idx);
        bus_idle = 1'b1;
        #1;
        chk(tag, {31'd0, tx_start}, {31'd0, exp_start});
        if (exp_start) chk(tag, 32'(tx_idx), 32'(exp_idx));
        @(negedge clk);
        bus_idle = 1'b0;
    endtask

    task automatic fin(input int res);
        tx_done = 1'b1; tx_res = 2'(res);
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_gab();
        gab_set = 1'b1;
        @(negedge clk);
        gab_set = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 flags", {req_o, abt_o, lab_o, err_o, irq_o}, '0);
        chk("R1 ctl", {29'd0, gab_o, busy_o, tx_start}, 0);

        // R2/R5: success with interrupt enabled
        wr(0, 1, 1, 1);
        go("R2 start b0", 1, 0);
        chk("R12 busy", {31'd0, busy_o}, 1);
        go("R12 no start while busy", 0, 0);
        fin(0);
        chk("R5 req cleared", 32'(req_o[0]), 0);
        chk("R5 irq set", 32'(irq_o[0]), 1);
        irq_clr = 3'b111; @(negedge clk); irq_clr = '0;
        // R5: success with interrupt disabled
        wr(0, 1, 1, 0);
        go("R5 start", 1, 0);
        fin(0);
        chk("R5 no irq ie=0", {29'd0, irq_o}, 0);

        // R6/R7: error then lost arbitration keep the request
        wr(1, 1, 2, 1);
        go("R6 start b1", 1, 1);
        fin(1);
        chk("R6 err/req/irq", {29'd0, err_o[1], req_o[1], irq_o[1]}, 3'b110);
        go("R6 retry", 1, 1);
        fin(2);
        chk("R7 lab/req/irq", {29'd0, lab_o[1], req_o[1], irq_o[1]}, 3'b110);
        wr(1, 1, 2, 1);
        chk("R4 flags cleared", {29'd0, abt_o[1], lab_o[1], err_o[1]}, 0);

        // R8: abort a buffer that is not on the bus
        wr(2, 1, 0, 1);
        wr(2, 0, 0, 1);
        chk("R8 req/abt/irq", {29'd0, req_o[2], abt_o[2], irq_o[2]}, 3'b010);
        wr(2, 1, 0, 1);
        chk("R4 abt cleared", 32'(abt_o[2]), 0);
        wr(2, 0, 0, 1);

        // R9: abort of the in-flight buffer, attempt succeeds
        go("R9 start b1", 1, 1);
        wr(1, 0, 2, 1);
        chk("R9 held", {30'd0, req_o[1], abt_o[1]}, 2'b10);
        fin(0);
        chk("R9 ok wins", {29'd0, req_o[1], abt_o[1], irq_o[1]}, 3'b001);
        irq_clr = 3'b111; @(negedge clk); irq_clr = '0;
        // R9: abort of the in-flight buffer, attempt fails
        wr(1, 1, 2, 1);
        go("R9 start b1 again", 1, 1);
        wr(1, 0, 2, 1);
        fin(1);
        chk("R9 err abort", {28'd0, req_o[1], abt_o[1], err_o[1], irq_o[1]}, 4'b0110);

        // R10: global abort with one buffer in flight
        wr(0, 1, 1, 1);
        wr(1, 1, 3, 1);
        go("R10 start b1", 1, 1);
        pulse_gab();
        chk("R10 set", {31'd0, gab_o}, 1);
        @(negedge clk);
        chk("R10 idle aborted", {29'd0, req_o}, 3'b010);
        chk("R10 abt b0", 32'(abt_o[0]), 1);
        fin(2);
        chk("R10 in-flight aborted", {29'd0, req_o[1], abt_o[1], lab_o[1]}, 3'b011);
        @(negedge clk);
        chk("R10 self clear", {31'd0, gab_o}, 0);
        // R10: no start while the global abort is set
        wr(2, 1, 1, 1);
        pulse_gab();
        go("R10 start blocked", 0, 0);
        @(negedge clk);
        chk("R10 all aborted", {28'd0, gab_o, req_o}, 0);

        // R11/R3: latest priority used, tie goes to higher index
        wr(0, 1, 3, 1);
        wr(2, 1, 0, 1);
        wr(0, 1, 0, 1);
        go("R11 R3 tie after rewrite", 1, 2);
        fin(0);
        go("R11 next b0", 1, 0);
        fin(0);

        // R12: completion report ignored while idle
        wr(2, 1, 1, 0);
        tx_done = 1'b1; tx_res = 2'b00;
        @(negedge clk);
        tx_done = 1'b0;
        chk("R12 done ignored", {30'd0, req_o[2], busy_o}, 2'b10);
        go("R12 start b2", 1, 2);
        fin(0);
        irq_clr = 3'b111; @(negedge clk); irq_clr = '0;

        // R2/R3 sweep: every non-empty request set against all priorities
        for (int m = 1; m < 8; m++) begin
            for (int p = 0; p < 64; p++) begin
                int best, bi;
                bit found;
                best = 0; bi = 0; found = 0;
                for (int i = 0; i < NBUF; i++) begin
                    int pr;
                    pr = (p >> (2 * i)) & 3;
                    wr(i, m[i], pr, 1);
                    if (m[i] && (!found || pr >= best)) begin
                        found = 1; best = pr; bi = i;
                    end
                end
                go("R2 R3 sweep pick", 1, bi);
                fin(2);
                pulse_gab();
                @(negedge clk);
                @(negedge clk);
                chk("R10 sweep clear", {28'd0, gab_o, req_o}, 0);
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule